// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Break Detection

This block turns one asynchronous serial line into characters. The line idles high. A character opens with a low start bit and then carries 7 or 8 data bits, least significant first. An optional even or odd parity bit may follow, and the character closes with one or two high stop bits. Every timing decision runs on a single-cycle enable that pulses sixteen times per bit period. The enable comes from a rate generator outside the block. The frame format is taken from configuration inputs, which are meant to stay steady while a character is on the line.

Each finished character is written into a 16-entry queue together with its own parity and framing flags. A host drains the queue through a valid/ready pop port. Four sticky status bits record a parity error, a framing error, an overrun and a break. One clear input resets all four. A break is reported when the line, after a framing error, stays low for at least the length of a whole character in the current format. The synchronized line level is also brought out, so the host can look at the line itself.

Top module: `async_char_rx`

## Requirements
- R1: With 8 data bits and parity off, a character sent least significant bit first appears on `pop_data` unchanged, with `pop_perr` and `pop_ferr` both 0.
- R2: With `cfg_eight`=0, seven data bits are received least significant bit first, and the stored byte has bit 7 equal to 0.
- R3: With `cfg_par_en`=1, a parity bit follows the data. `cfg_par_odd`=0 selects even parity and 1 selects odd. A mismatch sets that character's `pop_perr` and sets the sticky `st_perr`, and the character is still stored.
- R4: With `cfg_par_en`=0, no parity bit is expected, and `pop_perr` and `st_perr` stay 0.
- R5: With `cfg_two_stop`=1, only the first stop bit is checked. A low second stop bit causes no framing error and produces no extra character.
- R6: A low first stop bit sets that character's `pop_ferr` and the sticky `st_ferr`, and the character is still stored.
- R7: A start bit counts only if the line is still low at the eighth oversampling tick. A shorter low pulse produces no character.
- R8: The queue holds 16 characters. They leave in arrival order, one per cycle in which `pop_valid` and `pop_ready` are both 1.
- R9: A character that completes while 16 entries are held is discarded, `st_ovr` is set, and the 16 stored entries are kept.
- R10: `st_brk` is set when, after a framing error, the line stays low for one full frame time of the current format. A low period shorter than that does not set it.
- R11: `line_level` follows `rxd` through a two-stage synchronizer.
- R12: A one-cycle `st_clr` pulse clears all four sticky status bits.
- R13: After reset the queue is empty, all status bits are 0 and `line_level` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, asynchronous |
| cfg_eight | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one stop bit |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| pop_ready | input | 1 | Host takes the head entry |
| pop_valid | output | 1 | Queue holds at least one entry |
| pop_data | output | 8 | Head character |
| pop_perr | output | 1 | Parity error flag of the head character |
| pop_ferr | output | 1 | Framing error flag of the head character |
| st_clr | input | 1 | Clears all sticky status bits |
| st_perr | output | 1 | Sticky parity error |
| st_ferr | output | 1 | Sticky framing error |
| st_ovr | output | 1 | Sticky overrun |
| st_brk | output | 1 | Sticky break |
| line_level | output | 1 | Synchronized line level |

## Verification
The bench builds the block with its defaults: 16 ticks per bit and 16 queue entries. It makes one tick every four clocks, so a bit lasts 64 clocks. At that depth, seventeen characters sent without popping are enough to reach the overrun case. A break window of 160 ticks in the 8-bit, no-parity, one-stop format fits inside a short run, so both a low stretch too short to count as a break and one long enough can be driven. The mid-bit start check is exercised with a low pulse of five clocks.

// File: rtl/arx_pkg.sv
// Package: shared types for the serial character receiver.
// Assumes: characters are at most 8 bits wide.
package arx_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
    } arx_state_t;

    typedef struct packed {
        logic       perr;
        logic       ferr;
        logic [7:0] data;
    } arx_char_t;

    localparam int CHAR_W = $bits(arx_char_t);
endpackage

// File: rtl/arx_sync.sv
// Module: multi-stage synchronizer for the asynchronous serial line.
// Assumes: the idle level of the line is high, so every stage resets to 1.
module arx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the line level through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/arx_framer.sv
// Module: character framer. It confirms the start bit at mid-bit, samples the
// data, parity and first stop bit at their centres, and skips the second stop bit.
// Assumes: rx is already synchronized and the configuration is steady during a frame.
module arx_framer
    import arx_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx,
    input  logic      cfg_eight,
    input  logic      cfg_two_stop,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    output logic      push,
    output arx_char_t push_char
);
    localparam int HALF = OS / 2;
    localparam int CW   = $clog2(OS + HALF);
    localparam logic [CW-1:0] C_MID  = CW'(HALF - 1);
    localparam logic [CW-1:0] C_BIT  = CW'(OS - 1);
    localparam logic [CW-1:0] C_TAIL = CW'(OS + HALF - 1);

    arx_state_t    state;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    shreg;
    logic          par_bit;
    logic [7:0]    data_w;
    logic          perr_w;

    // Align the data: in 7-bit mode only the upper seven shifted bits are valid.
    assign data_w = cfg_eight ? shreg : {1'b0, shreg[7:1]};
    assign perr_w = cfg_par_en & (^data_w ^ par_bit ^ cfg_par_odd);

    // Step through the frame once per oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            push      <= 1'b0;
            push_char <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                cnt <= cnt + 1'b1;
                case (state)
                    S_IDLE: begin
                        cnt <= '0;
                        if (!rx) state <= S_START;
                    end
                    S_START: if (cnt == C_MID) begin
                        cnt   <= '0;
                        bitn  <= '0;
                        state <= rx ? S_IDLE : S_DATA;
                    end
                    S_DATA: if (cnt == C_BIT) begin
                        cnt   <= '0;
                        shreg <= {rx, shreg[7:1]};
                        bitn  <= bitn + 1'b1;
                        if (bitn == (cfg_eight ? 3'd7 : 3'd6))
                            state <= cfg_par_en ? S_PAR : S_STOP1;
                    end
                    S_PAR: if (cnt == C_BIT) begin
                        cnt     <= '0;
                        par_bit <= rx;
                        state   <= S_STOP1;
                    end
                    S_STOP1: if (cnt == C_BIT) begin
                        cnt       <= '0;
                        push      <= 1'b1;
                        push_char <= '{perr: perr_w, ferr: !rx, data: data_w};
                        state     <= cfg_two_stop ? S_STOP2 : S_IDLE;
                    end
                    S_STOP2: if (cnt == C_TAIL) begin
                        cnt   <= '0;
                        state <= S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/arx_fifo.sv
// Module: receive queue with a fill count. The head entry is read combinationally.
// Assumes: the caller never pushes while full and never pops while empty.
module arx_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] A_LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    // Store the pushed entry.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Advance the pointers and keep the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == A_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == A_LAST) ? '0 : rd_ptr + 1'b1;
            fill <= fill + {{($bits(fill)-1){1'b0}}, push}
                         - {{($bits(fill)-1){1'b0}}, pop};
        end
    end

    assign rdata = mem[rd_ptr];
endmodule

// File: rtl/arx_brk.sv
// Module: break detector. It arms on a framing error and counts oversampling
// ticks of continuous low line until one frame time has passed.
// Assumes: frame_ticks is at least 1 and stays steady while armed.
module arx_brk #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    input  logic          ferr_evt,
    input  logic [BW-1:0] frame_ticks,
    output logic          brk_evt
);
    logic          armed;
    logic [BW-1:0] cnt;

    // Count low ticks while armed; a high sample disarms and restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            cnt     <= '0;
            brk_evt <= 1'b0;
        end else begin
            brk_evt <= 1'b0;
            if (tick) begin
                if (rx) begin
                    armed <= 1'b0;
                    cnt   <= '0;
                end else if (armed) begin
                    if (cnt == frame_ticks - 1'b1) begin
                        brk_evt <= 1'b1;
                        armed   <= 1'b0;
                        cnt     <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
            if (ferr_evt) armed <= 1'b1;
        end
    end
endmodule

// File: rtl/async_char_rx.sv
// Module: top of the serial character receiver. It ties together the synchronizer,
// framer, queue and break detector, and holds the sticky status bits.
// Assumes: os_tick pulses OS times per bit period and lasts one cycle each time.
module async_char_rx
    import arx_pkg::*;
#(
    parameter int OS     = 16,
    parameter int DEPTH  = 16,
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       cfg_eight,
    input  logic       cfg_two_stop,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       pop_ready,
    output logic       pop_valid,
    output logic [7:0] pop_data,
    output logic       pop_perr,
    output logic       pop_ferr,
    input  logic       st_clr,
    output logic       st_perr,
    output logic       st_ferr,
    output logic       st_ovr,
    output logic       st_brk,
    output logic       line_level
);
    localparam int FW = $clog2(DEPTH + 1);
    localparam int BW = $clog2(OS * 13 + 1);

    logic          rx_s;
    logic          push;
    arx_char_t     push_char;
    arx_char_t     head;
    logic [FW-1:0] fill;
    logic          full;
    logic          pop;
    logic          brk_evt;
    logic [3:0]    frame_bits;
    logic [BW-1:0] frame_ticks;

    arx_sync #(.STAGES(STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
    );

    arx_framer #(.OS(OS)) framer_i (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
        .cfg_eight(cfg_eight), .cfg_two_stop(cfg_two_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .push(push), .push_char(push_char)
    );

    assign full = (fill == FW'(DEPTH));
    assign pop  = pop_valid & pop_ready;

    arx_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(push & !full), .wdata(push_char),
        .pop(pop), .rdata(head), .fill(fill)
    );

    // Frame length in ticks for the current format, used as the break window.
    assign frame_bits  = 4'd1 + (cfg_eight ? 4'd8 : 4'd7) + {3'b000, cfg_par_en}
                       + (cfg_two_stop ? 4'd2 : 4'd1);
    assign frame_ticks = BW'(frame_bits) * BW'(OS);

    arx_brk #(.BW(BW)) brk_i (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
        .ferr_evt(push & push_char.ferr), .frame_ticks(frame_ticks),
        .brk_evt(brk_evt)
    );

    // Sticky status: an event sets its bit, the clear input resets all four.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_perr <= 1'b0;
            st_ferr <= 1'b0;
            st_ovr  <= 1'b0;
            st_brk  <= 1'b0;
        end else begin
            st_perr <= (st_perr & !st_clr) | (push & push_char.perr);
            st_ferr <= (st_ferr & !st_clr) | (push & push_char.ferr);
            st_ovr  <= (st_ovr  & !st_clr) | (push & full);
            st_brk  <= (st_brk  & !st_clr) | brk_evt;
        end
    end

    assign pop_valid  = (fill != '0);
    assign pop_data   = head.data;
    assign pop_perr   = head.perr;
    assign pop_ferr   = head.ferr;
    assign line_level = rx_s;
endmodule

// File: rtl/arx_checker.sv
// Module: property checker for async_char_rx, attached with bind.
// Assumes: it sees the top's ports and a few internal nets of the top.
module arx_checker #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       st_clr,
    input logic                       st_perr,
    input logic                       st_ovr,
    input logic                       st_brk,
    input logic                       line_level,
    input logic                       pop_valid,
    input logic                       push,
    input logic                       push_bit7,
    input logic                       cfg_eight,
    input logic [$clog2(DEPTH+1)-1:0] fill
);
    // R8: the fill count never exceeds the depth.
    p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= ($clog2(DEPTH+1))'(DEPTH));

    // R8: the queue cannot become non-empty without a completed character.
    p_no_phantom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_valid && !push) |=> !pop_valid);

    // R9: overrun only rises after a cycle in which the queue was full.
    p_ovr_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_ovr) |-> $past(fill) == ($clog2(DEPTH+1))'(DEPTH));

    // R12: the sticky bits hold until cleared.
    p_ovr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ovr && !st_clr) |=> st_ovr);
    p_perr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_perr && !st_clr) |=> st_perr);

    // R2: a 7-bit character is stored with bit 7 at 0.
    p_seven_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !cfg_eight) |-> !push_bit7);

    // R10: a break is raised only from a low line sample.
    p_brk_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_brk) |-> $past(line_level, 2) == 1'b0);
endmodule

bind async_char_rx arx_checker #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .st_clr(st_clr), .st_perr(st_perr),
    .st_ovr(st_ovr), .st_brk(st_brk), .line_level(line_level),
    .pop_valid(pop_valid), .push(push), .push_bit7(push_char.data[7]),
    .cfg_eight(cfg_eight), .fill(fill)
);

// File: tb/async_char_rx_tb_top.sv
// Bench for async_char_rx: a table of frame vectors, then directed tests.
module async_char_rx_tb_top;
    localparam int BIT = 64;   // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick;
    logic       rxd = 1'b1;
    logic       cfg_eight = 1'b1, cfg_two_stop = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       pop_ready = 1'b0;
    logic       pop_valid;
    logic [7:0] pop_data;
    logic       pop_perr, pop_ferr;
    logic       st_clr = 1'b0;
    logic       st_perr, st_ferr, st_ovr, st_brk, line_level;
    logic [1:0] tdiv = 2'd0;
    int         checks = 0;
    int         failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    // Tick generator: one tick every four clocks.
    always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
    assign os_tick = (tdiv == 2'd3);

    async_char_rx dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .cfg_eight(cfg_eight), .cfg_two_stop(cfg_two_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .pop_ready(pop_ready), .pop_valid(pop_valid), .pop_data(pop_data),
        .pop_perr(pop_perr), .pop_ferr(pop_ferr), .st_clr(st_clr),
        .st_perr(st_perr), .st_ferr(st_ferr), .st_ovr(st_ovr), .st_brk(st_brk),
        .line_level(line_level)
    );

    // Vector fields: [13] eight [12] par_en [11] par_odd [10] two_stop
    //                [9] flip parity [8] low stop [7:0] data
    localparam logic [13:0] VEC [8] = '{
        {6'b100000, 8'hA5}, {6'b100000, 8'h01}, {6'b000000, 8'hFF},
        {6'b110000, 8'h3C}, {6'b111010, 8'h3C}, {6'b011100, 8'h2A},
        {6'b100001, 8'h80}, {6'b110110, 8'hC3}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit flip,
                              input logic stop1, input logic stop2);
        logic p;
        p = cfg_par_odd;
        drive_bit(1'b0);
        for (int i = 0; i < (cfg_eight ? 8 : 7); i++) begin
            drive_bit(d[i]);
            p ^= d[i];
        end
        if (cfg_par_en) drive_bit(p ^ flip);
        drive_bit(stop1);
        if (cfg_two_stop) drive_bit(stop2);
        drive_bit(1'b1);
    endtask

    task automatic pop_one(output logic [9:0] got, output bit ok);
        ok = 1'b0;
        got = '0;
        for (int i = 0; i < 3 * BIT; i++) begin
            if (pop_valid) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (ok) begin
            got = {pop_perr, pop_ferr, pop_data};
            pop_ready = 1'b1;
            @(negedge clk);
            pop_ready = 1'b0;
        end
    endtask

    task automatic drain();
        logic [9:0] g;
        bit ok;
        ok = 1'b1;
        while (ok) pop_one(g, ok);
    endtask

    task automatic pulse_clear();
        st_clr = 1'b1;
        @(negedge clk);
        st_clr = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired, run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [9:0] got;
        logic [7:0] ed;
        bit ok;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk(!pop_valid, "R13", "pop_valid after reset", pop_valid, 0);
        chk({st_perr, st_ferr, st_ovr, st_brk} == 4'b0, "R13", "status after reset",
            {st_perr, st_ferr, st_ovr, st_brk}, 0);
        chk(line_level, "R13", "line_level after reset", line_level, 1);
        repeat (BIT) @(negedge clk);

        // Table walk: R1 R2 R3 R4 R6
        foreach (VEC[k]) begin
            cfg_eight    = VEC[k][13];
            cfg_par_en   = VEC[k][12];
            cfg_par_odd  = VEC[k][11];
            cfg_two_stop = VEC[k][10];
            send_frame(VEC[k][7:0], VEC[k][9], ~VEC[k][8], 1'b1);
            ed = cfg_eight ? VEC[k][7:0] : {1'b0, VEC[k][6:0]};
            pop_one(got, ok);
            chk(ok, "R1", "character received", ok, 1);
            chk(got[7:0] == ed, cfg_eight ? "R1" : "R2", "data", got[7:0], ed);
            chk(got[9] == (VEC[k][12] & VEC[k][9]), cfg_par_en ? "R3" : "R4",
                "parity flag", got[9], VEC[k][12] & VEC[k][9]);
            chk(got[8] == VEC[k][8], "R6", "framing flag", got[8], VEC[k][8]);
        end
        chk(st_perr, "R3", "sticky parity after table", st_perr, 1);
        chk(st_ferr, "R6", "sticky framing after table", st_ferr, 1);

        // R12: clear all sticky bits
        pulse_clear();
        chk({st_perr, st_ferr, st_ovr, st_brk} == 4'b0, "R12", "status after clear",
            {st_perr, st_ferr, st_ovr, st_brk}, 0);

        // R4: parity off, no perr on any data
        cfg_eight = 1'b1; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
        send_frame(8'h7E, 1'b1, 1'b1, 1'b1);
        pop_one(got, ok);
        chk(ok && got == {2'b00, 8'h7E}, "R4", "no-parity frame", got, 10'h07E);
        chk(!st_perr, "R4", "st_perr stays 0", st_perr, 0);

        // R5: second stop bit low is ignored
        cfg_two_stop = 1'b1;
        send_frame(8'h5A, 1'b0, 1'b1, 1'b0);
        repeat (2 * BIT) @(negedge clk);
        pop_one(got, ok);
        chk(ok && got == {2'b00, 8'h5A}, "R5", "frame with low second stop", got, 10'h05A);
        pop_one(got, ok);
        chk(!ok, "R5", "no extra character", ok, 0);
        chk(!st_ferr, "R5", "no framing error", st_ferr, 0);
        cfg_two_stop = 1'b0;

        // R11 and R7: short low pulse, seen on line_level, no character
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        chk(!line_level, "R11", "line_level follows low", line_level, 0);
        repeat (2) @(negedge clk);
        rxd = 1'b1;
        repeat (3) @(negedge clk);
        chk(line_level, "R11", "line_level follows high", line_level, 1);
        repeat (2 * BIT) @(negedge clk);
        chk(!pop_valid, "R7", "glitch gives no character", pop_valid, 0);

        // R8 and R9: seventeen characters without popping
        for (int i = 0; i < 17; i++) send_frame(8'(i * 3 + 1), 1'b0, 1'b1, 1'b1);
        chk(st_ovr, "R9", "overrun set", st_ovr, 1);
        for (int i = 0; i < 16; i++) begin
            pop_one(got, ok);
            chk(ok && got[7:0] == 8'(i * 3 + 1), "R8", "queue order", got[7:0], i * 3 + 1);
        end
        @(negedge clk);
        chk(!pop_valid, "R9", "seventeenth character discarded", pop_valid, 0);
        pulse_clear();

        // R10: low stretch shorter than a frame gives no break
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(1'b1);
        for (int i = 0; i < 4; i++) drive_bit(1'b0);
        for (int i = 0; i < 14; i++) drive_bit(1'b1);
        drain();
        chk(st_ferr, "R10", "framing error seen", st_ferr, 1);
        chk(!st_brk, "R10", "short low gives no break", st_brk, 0);
        pulse_clear();

        // R10: framing error followed by a long low line gives a break
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(1'b1);
        for (int i = 0; i < 16; i++) drive_bit(1'b0);
        for (int i = 0; i < 14; i++) drive_bit(1'b1);
        drain();
        chk(st_brk, "R10", "break detected", st_brk, 1);
        pulse_clear();
        chk(!st_brk, "R12", "break cleared", st_brk, 0);

        // R13: reset in the middle of operation empties the queue
        send_frame(8'h33, 1'b0, 1'b0, 1'b1);
        chk(pop_valid && st_ferr, "R13", "state before reset", {pop_valid, st_ferr}, 3);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pop_valid, "R13", "queue empty after reset", pop_valid, 0);
        chk(!st_ferr, "R13", "status zero after reset", st_ferr, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule